// File: doc/BRIEF.md
# Reference Clock Loss-of-Signal Monitor

This block watches one reference clock for activity using a much faster, free-running monitor clock. The reference passes through a two-flop synchronizer, and its rising edges are detected in the monitor domain. A timeout counter runs on every monitor cycle and restarts from zero on each detected reference edge.

The first timeout with no reference edge raises a soft alarm. The soft alarm drives a freeze output that tells the downstream loop to stop adjusting. An edge that arrives before a second timeout clears the soft alarm. A second timeout in a row declares loss of signal instead.

A lost reference is requalified by counting rising edges, and the alarm clears only on the eighth. Another timeout during requalification restarts that count. Because the timeout is programmable, a gapped clock whose gaps are shorter than the timeout raises no alarm. Every change of alarm status produces a one-cycle interrupt pulse unless it is masked.

Top module: `ref_loss_monitor`

## Requirements
- R1: Each synchronized rising edge of the reference restarts the timeout count. Reference edges spaced 8 monitor cycles apart under a timeout of 10 never raise an alarm.
- R2: With a nonzero timeout T and no reference edge since reset is released, `soft_alarm` rises on exactly the T-th monitor clock edge after release.
- R3: `freeze` is high whenever `soft_alarm` or `los_alarm` is high, and low otherwise.
- R4: A reference edge that arrives while the soft alarm is active clears `soft_alarm` and `freeze` without raising `los_alarm`.
- R5: A second consecutive timeout raises `los_alarm` on the 2T-th edge after release. `soft_alarm` falls on the same edge, and the two alarms are never high together.
- R6: `los_alarm` clears only on the eighth detected rising edge of the returning reference. After seven edges it is still set.
- R7: A timeout during requalification keeps `los_alarm` set and restarts the edge count from zero.
- R8: `irq_pulse` is a one-cycle pulse, aligned with the cycle in which an alarm output changes. `irq_mask` bit 0 masks changes of `soft_alarm`, and bit 1 masks changes of `los_alarm`. At the soft-to-LOS step both alarms change, so the pulse fires unless both bits are set.
- R9: A timeout value of zero disables the monitor. No alarm is raised, and any active alarm clears one cycle after the zero is applied.
- R10: The timeout is 17 bits wide. A value of 65536 raises the soft alarm on edge 65536 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Reference clock under watch, asynchronous to clk |
| timeout_val | input | 17 | Timeout in monitor cycles; 0 disables the monitor |
| irq_mask | input | 2 | Bit 0 masks soft-alarm changes, bit 1 masks LOS changes |
| soft_alarm | output | 1 | First timeout seen, no edge since |
| los_alarm | output | 1 | Reference declared lost |
| freeze | output | 1 | Stop loop adjustment |
| irq_pulse | output | 1 | One-cycle pulse on an unmasked alarm change |

## Verification
The assertions take for granted that the reference stays high and low for at least two monitor cycles each, so that the synchronizer sees every rising edge. They also assume the timeout value changes only between scenarios. The stimulus drives each reference level for two full monitor cycles and writes the timeout only while reset is asserted or when testing the disable case. The bench sweeps timeouts from 1 to 12 and every mask value, and checks each monitor cycle against arithmetic expectations.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  typedef enum logic [1:0] {
    MON_OK   = 2'd0,
    MON_SOFT = 2'd1,
    MON_LOST = 2'd2
  } mon_state_t;
endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic rise_o
);
  // chain[SYNC_STAGES-1] is the synchronized level, the last bit its history
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-1:0], ref_in};
  end

  assign rise_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/refmon_timer.sv
module refmon_timer #(
  parameter int TW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic [TW-1:0] limit,
  output logic          expire_o,
  output logic          enabled_o
);
  logic [TW-1:0] cnt;
  logic          at_limit;

  assign enabled_o = |limit;
  // >= guards against a limit lowered below the running count
  assign at_limit  = (cnt >= (limit - TW'(1)));
  assign expire_o  = enabled_o & ~rise_i & at_limit;

  always_ff @(posedge clk) begin
    if (rst || !enabled_o || rise_i || at_limit) cnt <= '0;
    else                                          cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/refmon_fsm.sv
module refmon_fsm
  import refmon_pkg::*;
#(
  parameter int QUAL_EDGES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rise_i,
  input  logic       expire_i,
  input  logic       enabled_i,
  input  logic [1:0] mask_i,
  output logic       soft_o,
  output logic       los_o,
  output logic       freeze_o,
  output logic       irq_o
);
  localparam int QW = $clog2(QUAL_EDGES + 1);

  mon_state_t    state, nxt;
  logic [QW-1:0] qual, qual_nxt;
  logic          soft_nxt, los_nxt;

  always_comb begin
    nxt      = state;
    qual_nxt = qual;
    if (!enabled_i) begin
      nxt      = MON_OK;
      qual_nxt = '0;
    end else begin
      unique case (state)
        MON_OK: begin
          qual_nxt = '0;
          if (expire_i) nxt = MON_SOFT;
        end
        MON_SOFT: begin
          if (rise_i)        nxt = MON_OK;
          else if (expire_i) begin
            nxt      = MON_LOST;
            qual_nxt = '0;
          end
        end
        MON_LOST: begin
          if (expire_i) qual_nxt = '0;
          else if (rise_i) begin
            if (qual == QW'(QUAL_EDGES - 1)) begin
              nxt      = MON_OK;
              qual_nxt = '0;
            end else begin
              qual_nxt = qual + QW'(1);
            end
          end
        end
        default: nxt = MON_OK;
      endcase
    end
  end

  assign soft_nxt = (nxt == MON_SOFT);
  assign los_nxt  = (nxt == MON_LOST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= MON_OK;
      qual     <= '0;
      soft_o   <= 1'b0;
      los_o    <= 1'b0;
      freeze_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      state    <= nxt;
      qual     <= qual_nxt;
      soft_o   <= soft_nxt;
      los_o    <= los_nxt;
      freeze_o <= (nxt != MON_OK);
      irq_o    <= ((soft_nxt != soft_o) & ~mask_i[0]) |
                  ((los_nxt  != los_o)  & ~mask_i[1]);
    end
  end
endmodule

// File: rtl/ref_loss_monitor.sv
module ref_loss_monitor #(
  parameter int TOUT_W      = 17,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk_in,
  input  logic [TOUT_W-1:0] timeout_val,
  input  logic [1:0]        irq_mask,
  output logic              soft_alarm,
  output logic              los_alarm,
  output logic              freeze,
  output logic              irq_pulse
);
  logic ref_rise;
  logic tout_expire;
  logic mon_enabled;

  refmon_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .ref_in (ref_clk_in),
    .rise_o (ref_rise)
  );

  refmon_timer #(.TW(TOUT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (ref_rise),
    .limit     (timeout_val),
    .expire_o  (tout_expire),
    .enabled_o (mon_enabled)
  );

  refmon_fsm #(.QUAL_EDGES(QUAL_EDGES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (ref_rise),
    .expire_i  (tout_expire),
    .enabled_i (mon_enabled),
    .mask_i    (irq_mask),
    .soft_o    (soft_alarm),
    .los_o     (los_alarm),
    .freeze_o  (freeze),
    .irq_o     (irq_pulse)
  );
endmodule

// File: rtl/ref_loss_monitor_chk.sv
module ref_loss_monitor_chk #(
  parameter int TOUT_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_rise,
  input logic [TOUT_W-1:0] timeout_val,
  input logic              soft_alarm,
  input logic              los_alarm,
  input logic              freeze,
  input logic              irq_pulse
);
  // R3
  freeze_tracks_alarm_chk: assert property (@(posedge clk) disable iff (rst)
    freeze == (soft_alarm | los_alarm));

  // R5
  alarms_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({soft_alarm, los_alarm}) <= 1);

  // R5
  los_after_soft_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(los_alarm) |-> $past(soft_alarm));

  // R6
  los_clear_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(los_alarm) && ($past(timeout_val) != '0)) |-> $past(ref_rise));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout_val == '0) |=> (!soft_alarm && !los_alarm));

  // R8
  irq_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (!$stable(soft_alarm) || !$stable(los_alarm)));
endmodule

bind ref_loss_monitor ref_loss_monitor_chk #(.TOUT_W(TOUT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ref_rise    (ref_rise),
  .timeout_val (timeout_val),
  .soft_alarm  (soft_alarm),
  .los_alarm   (los_alarm),
  .freeze      (freeze),
  .irq_pulse   (irq_pulse)
);

// File: tb/test_ref_loss_monitor.sv
module test_ref_loss_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_clk_in = 1'b0;
  logic [16:0] timeout_val = '0;
  logic [1:0]  irq_mask = '0;
  logic        soft_alarm, los_alarm, freeze, irq_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ref_loss_monitor i_ref_loss_monitor (
    .clk(clk), .rst(rst), .ref_clk_in(ref_clk_in), .timeout_val(timeout_val),
    .irq_mask(irq_mask), .soft_alarm(soft_alarm), .los_alarm(los_alarm),
    .freeze(freeze), .irq_pulse(irq_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic do_reset(input int t, input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; ref_clk_in = 1'b0; timeout_val = 17'(t); irq_mask = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one rising edge, each level held two monitor cycles
  task automatic pulse_ref();
    ref_clk_in = 1'b1;
    repeat (2) @(negedge clk);
    ref_clk_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // reset state
    do_reset(5, 2'b00);
    check("R2 reset soft", soft_alarm, 0);
    check("R5 reset los", los_alarm, 0);
    check("R3 reset freeze", freeze, 0);
    check("R8 reset irq", irq_pulse, 0);

    // R2 R5 R8 R3: sweep timeout values, unmasked
    for (int t = 1; t <= 12; t++) begin
      do_reset(t, 2'b00);
      for (int c = 1; c <= 2 * t + 1; c++) begin
        @(negedge clk);
        check("R2 soft timing", soft_alarm, (c >= t && c < 2 * t) ? 1 : 0);
        check("R5 los timing", los_alarm, (c >= 2 * t) ? 1 : 0);
        check("R3 freeze", freeze, (c >= t) ? 1 : 0);
        check("R8 irq timing", irq_pulse, (c == t || c == 2 * t) ? 1 : 0);
      end
    end

    // R8: every mask value
    for (int m = 0; m < 4; m++) begin
      do_reset(3, 2'(m));
      for (int c = 1; c <= 8; c++) begin
        @(negedge clk);
        check("R8 masked irq", irq_pulse,
              ((c == 3 && m[0] == 0) || (c == 6 && m != 3)) ? 1 : 0);
      end
    end

    // R4: an edge while the soft alarm is active
    do_reset(10, 2'b00);
    wait_edges(10);
    check("R4 soft set", soft_alarm, 1);
    pulse_ref();
    check("R4 soft cleared", soft_alarm, 0);
    check("R4 freeze cleared", freeze, 0);
    check("R4 no los", los_alarm, 0);

    // R1: gapped reference, edges 8 cycles apart, timeout 10
    do_reset(10, 2'b00);
    for (int k = 0; k < 30; k++) begin
      pulse_ref();
      wait_edges(4);
      check("R1 gapped soft", soft_alarm, 0);
      check("R1 gapped los", los_alarm, 0);
    end

    // R6: requalification needs the eighth edge
    do_reset(10, 2'b00);
    wait_edges(20);
    check("R6 los set", los_alarm, 1);
    for (int k = 0; k < 7; k++) pulse_ref();
    check("R6 los after 7", los_alarm, 1);
    pulse_ref();
    check("R6 los after 8", los_alarm, 0);
    check("R6 freeze after 8", freeze, 0);

    // R7: a timeout during requalification restarts the count
    do_reset(10, 2'b00);
    wait_edges(20);
    for (int k = 0; k < 5; k++) pulse_ref();
    wait_edges(25);
    check("R7 los held", los_alarm, 1);
    check("R7 no soft", soft_alarm, 0);
    for (int k = 0; k < 7; k++) pulse_ref();
    check("R7 los after 7", los_alarm, 1);
    pulse_ref();
    check("R7 los after 8", los_alarm, 0);

    // R9: zero timeout disables, and clears an active alarm
    do_reset(0, 2'b00);
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      check("R9 disabled soft", soft_alarm, 0);
      check("R9 disabled los", los_alarm, 0);
    end
    do_reset(4, 2'b00);
    wait_edges(8);
    check("R9 los before disable", los_alarm, 1);
    timeout_val = '0;
    @(negedge clk);
    check("R9 los cleared", los_alarm, 0);
    check("R9 freeze cleared", freeze, 0);

    // R10: bit 16 of the timeout is honoured
    do_reset(65536, 2'b00);
    wait_edges(65535);
    check("R10 soft before limit", soft_alarm, 0);
    @(negedge clk);
    check("R10 soft at limit", soft_alarm, 1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule